// File: doc/BRIEF.md
# Shared SRAM Pool Address Router

This block sits between a processor's instruction and data request paths and one shared on-chip SRAM pool. Each request address is sorted into a destination: the tightly coupled region of the pool, the general system region of the pool, the boot memory, or the Flash. For pool destinations the block also computes the byte offset into the pool. The pool is split at build time. An instruction-side tightly coupled region comes first, a data-side region of the same size follows it, and the system region takes the rest of the 384 KB. The region size is a parameter and can be 32, 64 or 128 KB.

A single enable bit, written by software, controls the tightly coupled regions. After reset the bit is clear, so instruction fetches in the low code window go to boot memory. Once the bit is set, instruction fetches below the region size go to the pool and fetches above it go to Flash. Data requests to the data-side window while the bit is clear are reported as errors and do not reach any memory.

Each port is a request stream qualified by its valid input. The router is purely combinational and never stalls, so it has no ready output. A consumer sees the decision in the same cycle as the request and must take it in that cycle. When valid is low the outputs are held at their idle values. A write to the enable bit is captured on the clock edge and applies to every request presented after that edge.

Top module: `tcm_pool_router`

## Requirements
- R1: After reset the enable bit reads back as 0 on `cfg_rdata`.
- R2: When `cfg_we` is high at a rising clock edge, `cfg_wdata` is stored in the enable bit. The new value appears on `cfg_rdata` and steers routing only after that edge, never earlier in the same cycle.
- R3: The parameter `TCM_KB` (32, 64 or 128) sets both tightly coupled region sizes. The system region size is 384 KB minus twice that size. Two routers built with different sizes route the same address differently.
- R4: While the enable bit is 0, an instruction address below `CODE_SPAN` gives target code 3 (boot) and an offset equal to the address.
- R5: While the enable bit is 1, an instruction address below the region size gives target code 1 (tightly coupled) and a pool offset equal to the address.
- R6: While the enable bit is 1, an instruction address from the region size up to `CODE_SPAN` gives target code 4 (Flash) and an offset equal to the address.
- R7: An instruction address at or above `CODE_SPAN` gives target code 0, offset 0 and error 1, whatever the enable bit holds.
- R8: While the enable bit is 1, a data address in [`DTCM_BASE`, `DTCM_BASE`+size) gives target code 1 and a pool offset of size + (address − `DTCM_BASE`).
- R9: While the enable bit is 0, a data address in the data-side window gives target code 0, offset 0 and error 1.
- R10: A data address in [`SRAM_BASE`, `SRAM_BASE` + system size) gives target code 2 (system) and a pool offset of 2·size + (address − `SRAM_BASE`), whatever the enable bit holds.
- R11: Any other data address gives target code 0, offset 0 and error 1. This includes addresses beyond the end of the system region.
- R12: When a port's valid input is low, that port outputs target code 0, offset 0 and error 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the enable bit |
| cfg_wdata | input | 1 | Value to write into the enable bit |
| cfg_rdata | output | 1 | Current value of the enable bit |
| i_valid | input | 1 | Instruction request valid |
| i_addr | input | ADDR_W | Instruction request address |
| i_tgt | output | 3 | Instruction target code (0 none, 1 tightly coupled, 2 system, 3 boot, 4 Flash) |
| i_off | output | OFF_W | Instruction offset into the selected target |
| i_err | output | 1 | Instruction decode error |
| d_valid | input | 1 | Data request valid |
| d_addr | input | ADDR_W | Data request address |
| d_tgt | output | 3 | Data target code, same encoding as `i_tgt` |
| d_off | output | OFF_W | Data offset into the selected target |
| d_err | output | 1 | Data decode error |

## Verification
Assertions check on every cycle that each pool offset falls inside the band its target owns, that boot routing appears only with the bit clear, and that Flash routing appears only with the bit set and above the region. They also check that an error never comes with a target, that idle ports stay quiet, and that a write lands in the enable bit on the next edge. The exact offset arithmetic, the region boundaries that move with the size parameter, and the fact that a write has no effect before its clock edge can only be shown by the bench. The bench drives two routers of different sizes with directed boundary addresses and seeded random ones.

// File: rtl/tcm_router_pkg.sv
package tcm_router_pkg;
  typedef enum logic [2:0] {
    TGT_NONE  = 3'd0,
    TGT_TCM   = 3'd1,
    TGT_SRAM  = 3'd2,
    TGT_BOOT  = 3'd3,
    TGT_FLASH = 3'd4
  } tgt_e;

  localparam int unsigned KB = 1024;
endpackage

// File: rtl/tcm_enable_reg.sv
module tcm_enable_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic wdata,
  output logic en
);
  always_ff @(posedge clk) begin
    if (!rst_n)  en <= 1'b0;
    else if (we) en <= wdata;
  end

  AST_EN_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(we) |-> (en == $past(wdata))); // R2
  AST_EN_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(we) |-> $stable(en)); // R2
endmodule

// File: rtl/tcm_instr_decode.sv
module tcm_instr_decode
  import tcm_router_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned OFF_W     = 22,
  parameter int unsigned TCM_BYTES = 64 * 1024,
  parameter int unsigned CODE_SPAN = 32'h0040_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              tgt,
  output logic [OFF_W-1:0]  off,
  output logic              err
);
  localparam logic [ADDR_W-1:0] TCM_LIM  = ADDR_W'(TCM_BYTES);
  localparam logic [ADDR_W-1:0] CODE_LIM = ADDR_W'(CODE_SPAN);
  localparam logic [OFF_W-1:0]  TCM_OFF  = OFF_W'(TCM_BYTES);

  logic in_code, in_tcm;
  assign in_code = (addr < CODE_LIM);
  assign in_tcm  = (addr < TCM_LIM);

  always_comb begin
    tgt = TGT_NONE;
    off = '0;
    err = 1'b0;
    if (valid) begin
      if (!in_code) begin
        err = 1'b1;
      end else if (!en) begin
        tgt = TGT_BOOT;
        off = addr[OFF_W-1:0];
      end else if (in_tcm) begin
        tgt = TGT_TCM;
        off = addr[OFF_W-1:0];
      end else begin
        tgt = TGT_FLASH;
        off = addr[OFF_W-1:0];
      end
    end
  end

  AST_ITCM_BELOW_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt == TGT_TCM) |-> (en && off < TCM_OFF)); // R5
  AST_BOOT_ONLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt == TGT_BOOT) |-> !en); // R4
  AST_FLASH_ABOVE_TCM: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt == TGT_FLASH) |-> (en && addr >= TCM_LIM)); // R6
  AST_I_ERR_NO_TGT: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (tgt == TGT_NONE && off == '0)); // R7
  AST_I_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (tgt == TGT_NONE && !err && off == '0)); // R12
endmodule

// File: rtl/tcm_data_decode.sv
module tcm_data_decode
  import tcm_router_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned OFF_W      = 22,
  parameter int unsigned TCM_BYTES  = 64 * 1024,
  parameter int unsigned POOL_BYTES = 384 * 1024,
  parameter int unsigned DTCM_BASE  = 32'h2000_0000,
  parameter int unsigned SRAM_BASE  = 32'h2040_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              tgt,
  output logic [OFF_W-1:0]  off,
  output logic              err
);
  localparam int unsigned       SYS_BYTES = POOL_BYTES - 2 * TCM_BYTES;
  localparam logic [ADDR_W-1:0] DT_BASE   = ADDR_W'(DTCM_BASE);
  localparam logic [ADDR_W-1:0] SY_BASE   = ADDR_W'(SRAM_BASE);
  localparam logic [ADDR_W-1:0] DT_SPAN   = ADDR_W'(TCM_BYTES);
  localparam logic [ADDR_W-1:0] SY_SPAN   = ADDR_W'(SYS_BYTES);
  localparam logic [OFF_W-1:0]  DT_OFF    = OFF_W'(TCM_BYTES);
  localparam logic [OFF_W-1:0]  SY_OFF    = OFF_W'(2 * TCM_BYTES);
  localparam logic [OFF_W-1:0]  POOL_END  = OFF_W'(POOL_BYTES);

  logic [ADDR_W-1:0] dt_delta, sy_delta;
  logic              in_dt, in_sy;

  assign dt_delta = addr - DT_BASE;
  assign sy_delta = addr - SY_BASE;
  assign in_dt    = (addr >= DT_BASE) && (dt_delta < DT_SPAN);
  assign in_sy    = (addr >= SY_BASE) && (sy_delta < SY_SPAN);

  always_comb begin
    tgt = TGT_NONE;
    off = '0;
    err = 1'b0;
    if (valid) begin
      if (in_dt) begin
        if (en) begin
          tgt = TGT_TCM;
          off = DT_OFF + dt_delta[OFF_W-1:0];
        end else begin
          err = 1'b1;
        end
      end else if (in_sy) begin
        tgt = TGT_SRAM;
        off = SY_OFF + sy_delta[OFF_W-1:0];
      end else begin
        err = 1'b1;
      end
    end
  end

  AST_DTCM_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt == TGT_TCM) |-> (en && off >= DT_OFF && off < SY_OFF)); // R8
  AST_SRAM_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt == TGT_SRAM) |-> (off >= SY_OFF && off < POOL_END)); // R10
  AST_DTCM_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !en && addr >= DT_BASE && addr < DT_BASE + DT_SPAN) |-> err); // R9
  AST_D_ERR_NO_TGT: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (tgt == TGT_NONE && off == '0)); // R11
  AST_D_NO_BOOT_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt != TGT_BOOT && tgt != TGT_FLASH)); // R10
  AST_D_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (tgt == TGT_NONE && !err && off == '0)); // R12
endmodule

// File: rtl/tcm_pool_router.sv
module tcm_pool_router
  import tcm_router_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned TCM_KB    = 64,
  parameter int unsigned POOL_KB   = 384,
  parameter int unsigned CODE_SPAN = 32'h0040_0000,
  parameter int unsigned DTCM_BASE = 32'h2000_0000,
  parameter int unsigned SRAM_BASE = 32'h2040_0000,
  localparam int unsigned POOL_AW  = $clog2(POOL_KB * KB),
  localparam int unsigned CODE_AW  = $clog2(CODE_SPAN),
  localparam int unsigned OFF_W    = (POOL_AW > CODE_AW) ? POOL_AW : CODE_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_wdata,
  output logic              cfg_rdata,
  input  logic              i_valid,
  input  logic [ADDR_W-1:0] i_addr,
  output logic [2:0]        i_tgt,
  output logic [OFF_W-1:0]  i_off,
  output logic              i_err,
  input  logic              d_valid,
  input  logic [ADDR_W-1:0] d_addr,
  output logic [2:0]        d_tgt,
  output logic [OFF_W-1:0]  d_off,
  output logic              d_err
);
  localparam int unsigned TCM_BYTES  = TCM_KB * KB;
  localparam int unsigned POOL_BYTES = POOL_KB * KB;

  generate
    if (!(TCM_KB == 32 || TCM_KB == 64 || TCM_KB == 128)) begin : g_bad_size
      $error("tcm_pool_router: TCM_KB must be 32, 64 or 128");
    end
    if (2 * TCM_BYTES > POOL_BYTES) begin : g_bad_pool
      $error("tcm_pool_router: pool smaller than both regions");
    end
  endgenerate

  logic en;
  tgt_e i_tgt_e, d_tgt_e;

  tcm_enable_reg u_en (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .en    (en)
  );

  tcm_instr_decode #(
    .ADDR_W    (ADDR_W),
    .OFF_W     (OFF_W),
    .TCM_BYTES (TCM_BYTES),
    .CODE_SPAN (CODE_SPAN)
  ) u_idec (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .valid (i_valid),
    .addr  (i_addr),
    .tgt   (i_tgt_e),
    .off   (i_off),
    .err   (i_err)
  );

  tcm_data_decode #(
    .ADDR_W     (ADDR_W),
    .OFF_W      (OFF_W),
    .TCM_BYTES  (TCM_BYTES),
    .POOL_BYTES (POOL_BYTES),
    .DTCM_BASE  (DTCM_BASE),
    .SRAM_BASE  (SRAM_BASE)
  ) u_ddec (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .valid (d_valid),
    .addr  (d_addr),
    .tgt   (d_tgt_e),
    .off   (d_off),
    .err   (d_err)
  );

  assign cfg_rdata = en;
  assign i_tgt     = i_tgt_e;
  assign d_tgt     = d_tgt_e;

  AST_RESET_CLEARS_EN: assert property (@(posedge clk)
    !rst_n |=> !cfg_rdata); // R1
  AST_ONE_PORT_TCM_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (i_tgt_e == TGT_TCM || d_tgt_e == TGT_TCM) |-> cfg_rdata); // R3
endmodule

// File: tb/tcm_pool_router_bench.sv
`timescale 1ns/100ps
module tcm_pool_router_bench;
  localparam int unsigned CODE = 32'h0040_0000;
  localparam int unsigned DB   = 32'h2000_0000;
  localparam int unsigned SB   = 32'h2040_0000;
  localparam int unsigned POOL = 384 * 1024;
  localparam int unsigned T64  = 64 * 1024;
  localparam int unsigned T128 = 128 * 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_wdata = 1'b0;
  logic i_valid = 1'b0, d_valid = 1'b0;
  logic [31:0] i_addr = '0, d_addr = '0;

  logic        rd_a, rd_b;
  logic [2:0]  it_a, dt_a, it_b, dt_b;
  logic [21:0] io_a, do_a, io_b, do_b;
  logic        ie_a, de_a, ie_b, de_b;

  int nchk = 0, nerr = 0;
  bit en_m = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tcm_pool_router #(.TCM_KB(64)) u_tcm_pool_router (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(rd_a),
    .i_valid(i_valid), .i_addr(i_addr), .i_tgt(it_a), .i_off(io_a), .i_err(ie_a),
    .d_valid(d_valid), .d_addr(d_addr), .d_tgt(dt_a), .d_off(do_a), .d_err(de_a));

  tcm_pool_router #(.TCM_KB(128)) u_tcm_pool_router_k128 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(rd_b),
    .i_valid(i_valid), .i_addr(i_addr), .i_tgt(it_b), .i_off(io_b), .i_err(ie_b),
    .d_valid(d_valid), .d_addr(d_addr), .d_tgt(dt_b), .d_off(do_b), .d_err(de_b));

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model(input int unsigned tb, input bit en, input bit iport, input bit v,
                       input logic [31:0] a, output logic [2:0] t, output logic [21:0] o,
                       output logic e, output string req);
    t = 3'd0; o = '0; e = 1'b0;
    if (!v) begin
      req = "R12";
    end else if (iport) begin
      if (a >= CODE)    begin e = 1'b1; req = "R7"; end
      else if (!en)     begin t = 3'd3; o = a[21:0]; req = "R4"; end
      else if (a < tb)  begin t = 3'd1; o = a[21:0]; req = "R5"; end
      else              begin t = 3'd4; o = a[21:0]; req = "R6"; end
    end else begin
      if (a >= DB && (a - DB) < tb) begin
        if (en) begin t = 3'd1; o = 22'(tb + (a - DB)); req = "R8"; end
        else    begin e = 1'b1; req = "R9"; end
      end else if (a >= SB && (a - SB) < (POOL - 2 * tb)) begin
        t = 3'd2; o = 22'(2 * tb + (a - SB)); req = "R10";
      end else begin
        e = 1'b1; req = "R11";
      end
    end
  endtask

  task automatic probe();
    logic [2:0] t; logic [21:0] o; logic e; string req;
    model(T64, en_m, 1'b1, i_valid, i_addr, t, o, e, req);
    check(req, "k64 instr", {it_a, io_a, ie_a}, {t, o, e});
    model(T64, en_m, 1'b0, d_valid, d_addr, t, o, e, req);
    check(req, "k64 data", {dt_a, do_a, de_a}, {t, o, e});
    model(T128, en_m, 1'b1, i_valid, i_addr, t, o, e, req);
    check(req, "k128 instr", {it_b, io_b, ie_b}, {t, o, e});
    model(T128, en_m, 1'b0, d_valid, d_addr, t, o, e, req);
    check(req, "k128 data", {dt_b, do_b, de_b}, {t, o, e});
  endtask

  task automatic drive(bit iv, logic [31:0] ia, bit dv, logic [31:0] da);
    @(negedge clk);
    i_valid = iv; i_addr = ia; d_valid = dv; d_addr = da;
    #1 probe();
  endtask

  task automatic set_en(bit v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    i_valid = 1'b1; i_addr = 32'h0;
    #1;
    check("R2", "readback before edge", {31'd0, rd_a}, {31'd0, en_m});
    probe();
    @(negedge clk);
    cfg_we = 1'b0;
    en_m = v;
    #1;
    check("R2", "readback after edge k64", {31'd0, rd_a}, {31'd0, v});
    check("R2", "readback after edge k128", {31'd0, rd_b}, {31'd0, v});
    probe();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "reset enable k64", {31'd0, rd_a}, 32'd0);
    check("R1", "reset enable k128", {31'd0, rd_b}, 32'd0);
    probe(); // R12 idle after reset

    // enable clear: boot window, errors, system region
    drive(1, 32'h0000_0000, 1, DB);
    drive(1, T64 - 4, 1, SB);
    drive(1, CODE - 1, 1, SB + POOL - 2 * T128 - 1);
    drive(1, CODE, 1, SB + POOL - 2 * T64 - 1);
    drive(1, 32'hFFFF_FFFC, 1, SB + POOL - 2 * T64);

    set_en(1'b1);
    drive(1, T64 - 1, 1, DB + T64 - 1);
    drive(1, T64, 1, DB + T64);
    drive(1, T128 - 1, 1, SB + T128);
    drive(1, T128, 1, DB - 1);
    // R3: size-dependent routing at the same address
    drive(1, T64, 1, DB + T64);
    check("R3", "k64 instr above 64K is flash", {29'd0, it_a}, 32'd4);
    check("R3", "k128 instr above 64K is tcm", {29'd0, it_b}, 32'd1);
    check("R3", "k64 data past window errors", {31'd0, de_a}, 32'd1);
    check("R3", "k128 data pool offset", {10'd0, do_b}, T128 + T64);
    drive(0, T64, 1, SB + T128);
    check("R3", "k64 sys offset", {10'd0, do_a}, 2 * T64 + T128);
    check("R3", "k128 sys end errors", {31'd0, de_b}, 32'd1);
    drive(0, 32'h0, 0, DB); // R12 idle with enable set

    set_en(1'b0);
    drive(1, 32'h10, 1, DB + 32'h10);

    for (int n = 0; n < 1500; n++) begin
      logic [31:0] ia, da;
      if ($urandom_range(0, 9) == 0) set_en(1'($urandom_range(0, 1)));
      case ($urandom_range(0, 3))
        0: ia = $urandom_range(0, T128 + 32'h100);
        1: ia = $urandom_range(0, CODE - 1);
        2: ia = CODE + $urandom_range(0, 32'hFFFF);
        default: ia = $urandom;
      endcase
      case ($urandom_range(0, 3))
        0: da = DB + $urandom_range(0, T128 + 32'h100);
        1: da = SB + $urandom_range(0, POOL);
        2: da = DB + $urandom_range(0, 32'h7F_FFFF);
        default: da = $urandom;
      endcase
      drive(1'($urandom_range(0, 7) != 0), ia, 1'($urandom_range(0, 7) != 0), da);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule